// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests from peripheral lines and selects the one the core should service next. Each line has an enable bit, a pending bit and an 8-bit priority, where a smaller number is more urgent. Among the lines that are both pending and enabled, the controller presents the most urgent one to the core together with its number. The core acknowledges a presented interrupt to make it active and signals the end of a handler with a return strobe. A separate non-maskable request outranks everything.

Software programs the controller through a word-addressed register port. The port carries a privilege qualifier. Enables and pendings are changed through separate set and clear banks, so a write only touches the bits written as 1. A grouping field splits each priority into a preemption group and a subpriority. Only the group decides whether a new interrupt may interrupt a running handler. When a handler returns while another eligible interrupt waits, that interrupt is offered in the same cycle as the return. The core can therefore chain straight into the next handler.

Top module: `pvic_top`

## Requirements
- R1: A synchronous reset clears all enables, pendings, priorities, active bits, the grouping field and the non-maskable state. In the first cycle after reset, no request is presented.
- R2: The set-enable bank spans word addresses 0x040–0x047. Bit b of word k refers to line 32k+b. Writing 1 enables that line, and writing 0 changes nothing. Reading the bank returns the enable bits, with 0 for lines that do not exist.
- R3: The clear-enable bank spans word addresses 0x060–0x067 and uses the same bit layout as R2. Writing 1 disables the line. Reading it also returns the enable bits.
- R4: The set-pending bank is at 0x080–0x087 and the clear-pending bank at 0x0A0–0x0A7, both with the R2 bit layout. Reading either bank returns the pending bits. If a clear meets any set in the same cycle, the clear wins.
- R5: Priorities sit at word addresses 0x100–0x13B. Byte n (bits 8n+7:8n) of word 0x100+k holds the priority of line 4k+n. The grouping value g sits in bits 2:0 of word 0x140.
- R6: A level line sets pending on every cycle it is high while the line is not active. With the default parameters, lines 8–15 and 32–39 are pulse lines instead: a pulse line sets pending only on a 0-to-1 transition. Pending stays latched until it is acknowledged or cleared.
- R7: The presented maskable interrupt is the enabled pending line with the smallest priority value. On a tie, the lower line number wins. Selection uses the register contents of the current cycle.
- R8: A maskable line is presented only when no line is active, or when its group value is strictly smaller than the smallest group value among the active lines. The group value is the priority with bits g:0 cleared, so g=7 allows no preemption.
- R9: Acknowledging a presented interrupt clears its pending bit and sets it active at the same clock edge. An acknowledge with nothing presented has no effect.
- R10: A return ends the non-maskable handler if that is active. Otherwise it clears the active line with the smallest priority value, taking the lower number on a tie. In the return cycle, selection already ignores the returning handler, and `core_tail` marks a request presented in that cycle.
- R11: A 0-to-1 transition of `nmi_in` latches a non-maskable request. It is presented with `core_irq_nmi`=1 and number 0, above every maskable line and regardless of any enable. While it is active, no maskable line is presented.
- R12: An unprivileged access writes nothing and reads 0. `bus_err` is high in the single cycle after each unprivileged access and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_IRQ | Peripheral request lines |
| nmi_in | input | 1 | Non-maskable request |
| bus_req | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | Access is privileged |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| bus_err | output | 1 | Denied access, one cycle later |
| core_irq_valid | output | 1 | A request is presented |
| core_irq_nmi | output | 1 | The presented request is non-maskable |
| core_irq_id | output | 8 | Number of the presented line |
| core_ack | input | 1 | Core accepts the presented request |
| core_eret | input | 1 | Core returns from a handler |
| core_tail | output | 1 | Request presented during a return (chaining) |

## Verification
The bound checker watches, on every cycle, the handshakes that can be judged locally. These are the quiet state after reset, the denied-access flag and zero read data, the non-maskable request being cleared after acknowledgement, the consistency of the chaining flag, and the presented number staying in range. Behaviour that depends on accumulated state can only be shown by the bench's cycle-accurate model and its scenarios. That includes which line wins under ties, preemption decisions as the grouping value changes, tail-chaining into the next handler, level re-pending after a return, and pulse latching.

// File: rtl/pvic_pkg.sv
package pvic_pkg;

    localparam int PRIO_W  = 8;
    localparam int ID_W    = 8;
    localparam int WADDR_W = 10;
    localparam int DATA_W  = 32;
    localparam int GRP_W   = 3;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [ID_W-1:0]   irq_id_t;

    typedef enum logic [2:0] {
        BK_NONE,
        BK_SETEN,
        BK_CLREN,
        BK_SETPD,
        BK_CLRPD,
        BK_PRIO,
        BK_GROUP
    } bank_e;

    typedef struct packed {
        bank_e      bank;
        logic [5:0] word;
    } decode_t;

    typedef struct packed {
        logic    valid;
        irq_id_t id;
        prio_t   prio;
    } pick_t;

    // word address -> register bank and word index within it
    function automatic decode_t decode_addr(input logic [WADDR_W-1:0] w);
        decode_t d;
        d.bank = BK_NONE;
        d.word = '0;
        if (w[9:3] == 7'h08) begin
            d.bank = BK_SETEN;
            d.word = {3'b000, w[2:0]};
        end else if (w[9:3] == 7'h0C) begin
            d.bank = BK_CLREN;
            d.word = {3'b000, w[2:0]};
        end else if (w[9:3] == 7'h10) begin
            d.bank = BK_SETPD;
            d.word = {3'b000, w[2:0]};
        end else if (w[9:3] == 7'h14) begin
            d.bank = BK_CLRPD;
            d.word = {3'b000, w[2:0]};
        end else if (w[9:6] == 4'h4 && w[5:0] < 6'd60) begin
            d.bank = BK_PRIO;
            d.word = w[5:0];
        end else if (w == 10'h140) begin
            d.bank = BK_GROUP;
        end
        return d;
    endfunction

    // bits of a priority that form the preemption group
    function automatic prio_t group_mask(input logic [GRP_W-1:0] g);
        return prio_t'(9'h0FF << (4'(g) + 4'd1));
    endfunction

endpackage

// File: rtl/pvic_pick.sv
module pvic_pick
    import pvic_pkg::*;
#(
    parameter int N = 40
) (
    input  logic              [N-1:0] cand,
    input  prio_t             [N-1:0] prio,
    output pick_t                     best
);

    // strict compare keeps the lowest index on equal priority
    always_comb begin
        best = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!best.valid || prio[i] < best.prio)) begin
                best.valid = 1'b1;
                best.id    = irq_id_t'(i);
                best.prio  = prio[i];
            end
        end
    end

endmodule

// File: rtl/pvic_regs.sv
module pvic_regs
    import pvic_pkg::*;
#(
    parameter int NUM_IRQ = 40
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_req,
    input  logic                       bus_we,
    input  logic [WADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    input  logic                       bus_priv,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic                       bus_err,
    input  logic [NUM_IRQ-1:0]         pend,
    output logic [NUM_IRQ-1:0]         enable,
    output prio_t [NUM_IRQ-1:0]        prio,
    output logic [GRP_W-1:0]           group_sel,
    output logic [NUM_IRQ-1:0]         sw_set_pend,
    output logic [NUM_IRQ-1:0]         sw_clr_pend
);

    localparam int LINES_PER_WORD = DATA_W;
    localparam int PRIO_PER_WORD  = DATA_W / PRIO_W;

    decode_t              dec;
    logic                 wr_ok;
    logic                 rd_ok;
    logic                 deny;
    logic [NUM_IRQ-1:0]   word_bits;
    logic [NUM_IRQ-1:0]   set_en;
    logic [NUM_IRQ-1:0]   clr_en;

    assign dec   = decode_addr(bus_addr);
    assign wr_ok = bus_req & bus_we & bus_priv;
    assign rd_ok = bus_req & ~bus_we & bus_priv;
    assign deny  = bus_req & ~bus_priv;

    // spread the written word onto the lines it covers
    always_comb begin
        for (int i = 0; i < NUM_IRQ; i++) begin
            word_bits[i] = (dec.word == 6'(i / LINES_PER_WORD)) && bus_wdata[i % LINES_PER_WORD];
        end
    end

    assign set_en      = (wr_ok && dec.bank == BK_SETEN) ? word_bits : '0;
    assign clr_en      = (wr_ok && dec.bank == BK_CLREN) ? word_bits : '0;
    assign sw_set_pend = (wr_ok && dec.bank == BK_SETPD) ? word_bits : '0;
    assign sw_clr_pend = (wr_ok && dec.bank == BK_CLRPD) ? word_bits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            enable    <= '0;
            prio      <= '0;
            group_sel <= '0;
            bus_err   <= 1'b0;
        end else begin
            enable  <= (enable | set_en) & ~clr_en;
            bus_err <= deny;
            if (wr_ok && dec.bank == BK_GROUP) begin
                group_sel <= bus_wdata[GRP_W-1:0];
            end
            for (int i = 0; i < NUM_IRQ; i++) begin
                if (wr_ok && dec.bank == BK_PRIO && dec.word == 6'(i / PRIO_PER_WORD)) begin
                    prio[i] <= bus_wdata[(i % PRIO_PER_WORD)*PRIO_W +: PRIO_W];
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_ok) begin
            case (dec.bank)
                BK_SETEN, BK_CLREN: begin
                    for (int i = 0; i < NUM_IRQ; i++) begin
                        if (dec.word == 6'(i / LINES_PER_WORD)) bus_rdata[i % LINES_PER_WORD] = enable[i];
                    end
                end
                BK_SETPD, BK_CLRPD: begin
                    for (int i = 0; i < NUM_IRQ; i++) begin
                        if (dec.word == 6'(i / LINES_PER_WORD)) bus_rdata[i % LINES_PER_WORD] = pend[i];
                    end
                end
                BK_PRIO: begin
                    for (int i = 0; i < NUM_IRQ; i++) begin
                        if (dec.word == 6'(i / PRIO_PER_WORD)) begin
                            bus_rdata[(i % PRIO_PER_WORD)*PRIO_W +: PRIO_W] = prio[i];
                        end
                    end
                end
                BK_GROUP: bus_rdata[GRP_W-1:0] = group_sel;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pvic_pend.sv
module pvic_pend #(
    parameter int                 NUM_IRQ     = 40,
    parameter logic [NUM_IRQ-1:0] PULSE_LINES = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic [NUM_IRQ-1:0] active,
    input  logic [NUM_IRQ-1:0] sw_set,
    input  logic [NUM_IRQ-1:0] sw_clr,
    input  logic [NUM_IRQ-1:0] ack_clr,
    output logic [NUM_IRQ-1:0] pend
);

    logic [NUM_IRQ-1:0] hw_set;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        if (PULSE_LINES[i]) begin : g_pulse
            logic line_q;
            always_ff @(posedge clk) begin
                if (rst) line_q <= 1'b0;
                else     line_q <= irq_in[i];
            end
            assign hw_set[i] = irq_in[i] & ~line_q;
        end else begin : g_level
            assign hw_set[i] = irq_in[i] & ~active[i];
        end
    end

    // a clear of either kind beats any set in the same cycle
    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend | hw_set | sw_set) & ~(sw_clr | ack_clr);
    end

endmodule

// File: rtl/pvic_top.sv
module pvic_top
    import pvic_pkg::*;
#(
    parameter int                 NUM_IRQ     = 40,
    parameter logic [NUM_IRQ-1:0] PULSE_LINES = 40'hFF_0000_FF00
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               nmi_in,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [9:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    input  logic               bus_priv,
    output logic [31:0]        bus_rdata,
    output logic               bus_err,
    output logic               core_irq_valid,
    output logic               core_irq_nmi,
    output logic [7:0]         core_irq_id,
    input  logic               core_ack,
    input  logic               core_eret
    ,
    output logic               core_tail
);

    logic [NUM_IRQ-1:0]  enable;
    logic [NUM_IRQ-1:0]  pend;
    logic [NUM_IRQ-1:0]  active;
    prio_t [NUM_IRQ-1:0] prio;
    logic [GRP_W-1:0]    group_sel;
    logic [NUM_IRQ-1:0]  sw_set_pend;
    logic [NUM_IRQ-1:0]  sw_clr_pend;
    logic [NUM_IRQ-1:0]  ret_oh;
    logic [NUM_IRQ-1:0]  take_oh;
    logic [NUM_IRQ-1:0]  active_after;
    pick_t               best_p;
    pick_t               ret_p;
    pick_t               exec_p;
    prio_t               gmask;
    logic                eret_mask;
    logic                nmi_q;
    logic                nmi_pend;
    logic                nmi_act;
    logic                nmi_act_after;
    logic                nmi_show;
    logic                mask_show;
    logic                take_nmi;
    logic                take_mask;

    pvic_regs #(.NUM_IRQ(NUM_IRQ)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_priv   (bus_priv),
        .bus_rdata  (bus_rdata),
        .bus_err    (bus_err),
        .pend       (pend),
        .enable     (enable),
        .prio       (prio),
        .group_sel  (group_sel),
        .sw_set_pend(sw_set_pend),
        .sw_clr_pend(sw_clr_pend)
    );

    pvic_pend #(.NUM_IRQ(NUM_IRQ), .PULSE_LINES(PULSE_LINES)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .irq_in (irq_in),
        .active (active),
        .sw_set (sw_set_pend),
        .sw_clr (sw_clr_pend),
        .ack_clr(take_oh),
        .pend   (pend)
    );

    // most urgent pending and enabled line
    pvic_pick #(.N(NUM_IRQ)) u_pick_pend (
        .cand(pend & enable),
        .prio(prio),
        .best(best_p)
    );

    // handler that a return would end
    pvic_pick #(.N(NUM_IRQ)) u_pick_ret (
        .cand(active),
        .prio(prio),
        .best(ret_p)
    );

    assign eret_mask = core_eret & ~nmi_act;

    always_comb begin
        for (int i = 0; i < NUM_IRQ; i++) begin
            ret_oh[i]  = eret_mask && ret_p.valid && (ret_p.id == irq_id_t'(i));
            take_oh[i] = take_mask && (best_p.id == irq_id_t'(i));
        end
    end

    assign active_after = active & ~ret_oh;

    // execution level once this cycle's return is applied
    pvic_pick #(.N(NUM_IRQ)) u_pick_exec (
        .cand(active_after),
        .prio(prio),
        .best(exec_p)
    );

    assign gmask         = group_mask(group_sel);
    assign nmi_act_after = nmi_act & ~core_eret;
    assign nmi_show      = nmi_pend & ~nmi_act_after;
    assign mask_show     = best_p.valid && !nmi_act_after &&
                           (!exec_p.valid || ((best_p.prio & gmask) < (exec_p.prio & gmask)));
    assign take_nmi      = core_ack & nmi_show;
    assign take_mask     = core_ack & ~nmi_show & mask_show;

    assign core_irq_valid = nmi_show | mask_show;
    assign core_irq_nmi   = nmi_show;
    assign core_irq_id    = (!nmi_show && mask_show) ? best_p.id : '0;
    assign core_tail      = core_eret & core_irq_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= '0;
            nmi_q    <= 1'b0;
            nmi_pend <= 1'b0;
            nmi_act  <= 1'b0;
        end else begin
            active   <= active_after | take_oh;
            nmi_q    <= nmi_in;
            nmi_pend <= (nmi_pend & ~take_nmi) | (nmi_in & ~nmi_q);
            nmi_act  <= nmi_act_after | take_nmi;
        end
    end

endmodule

// File: rtl/pvic_checker.sv
module pvic_checker #(
    parameter int NUM_IRQ = 40
) (
    input logic        clk,
    input logic        rst,
    input logic        bus_req,
    input logic        bus_we,
    input logic        bus_priv,
    input logic [31:0] bus_rdata,
    input logic        bus_err,
    input logic        core_irq_valid,
    input logic        core_irq_nmi,
    input logic [7:0]  core_irq_id,
    input logic        core_ack,
    input logic        core_eret,
    input logic        core_tail
);

    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !core_irq_valid);

    assert_id_in_range_R7: assert property (@(posedge clk) disable iff (rst)
        (core_irq_valid && !core_irq_nmi) |-> (core_irq_id < 8'(NUM_IRQ)));

    assert_nmi_taken_R9: assert property (@(posedge clk) disable iff (rst)
        (core_ack && core_irq_nmi) |=> !core_irq_nmi);

    assert_tail_flag_R10: assert property (@(posedge clk) disable iff (rst)
        core_tail |-> (core_eret && core_irq_valid));

    assert_nmi_form_R11: assert property (@(posedge clk) disable iff (rst)
        core_irq_nmi |-> (core_irq_valid && core_irq_id == 8'd0));

    assert_deny_flag_R12: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_priv) |=> bus_err);

    assert_no_stray_err_R12: assert property (@(posedge clk) disable iff (rst)
        !(bus_req && !bus_priv) |=> !bus_err);

    assert_deny_read_zero_R12: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_priv && !bus_we) |-> (bus_rdata == 32'd0));

endmodule

bind pvic_top pvic_checker #(.NUM_IRQ(NUM_IRQ)) u_pvic_checker (
    .clk           (clk),
    .rst           (rst),
    .bus_req       (bus_req),
    .bus_we        (bus_we),
    .bus_priv      (bus_priv),
    .bus_rdata     (bus_rdata),
    .bus_err       (bus_err),
    .core_irq_valid(core_irq_valid),
    .core_irq_nmi  (core_irq_nmi),
    .core_irq_id   (core_irq_id),
    .core_ack      (core_ack),
    .core_eret     (core_eret),
    .core_tail     (core_tail)
);

// File: tb/pvic_top_bench.sv
`timescale 1ns/1ps
module pvic_top_bench;

    localparam int N = 40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  irq_in = '0;
    logic          nmi_in = 1'b0;
    logic          bus_req = 1'b0;
    logic          bus_we = 1'b0;
    logic [9:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_priv = 1'b1;
    logic [31:0]   bus_rdata;
    logic          bus_err;
    logic          core_irq_valid;
    logic          core_irq_nmi;
    logic [7:0]    core_irq_id;
    logic          core_ack = 1'b0;
    logic          core_eret = 1'b0;
    logic          core_tail;

    always #4 clk = ~clk;

    pvic_top #(.NUM_IRQ(N), .PULSE_LINES(40'hFF_0000_FF00)) u_pvic_top (
        .clk(clk), .rst(rst), .irq_in(irq_in), .nmi_in(nmi_in),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_priv(bus_priv), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .core_irq_valid(core_irq_valid),
        .core_irq_nmi(core_irq_nmi), .core_irq_id(core_irq_id),
        .core_ack(core_ack), .core_eret(core_eret), .core_tail(core_tail)
    );

    // reference model state
    int en[N], pd[N], pr[N], act[N], lq[N];
    int grp, nmi_q, nmi_pd, nmi_a, err_q;
    int m_valid, m_nmi, m_id, m_tail, m_best, m_ret, m_eretm, m_tnmi, m_tmask;
    logic [31:0] m_rdata;

    int    n_cmp = 0;
    int    n_bad = 0;
    string phase = "R1";
    bit    started = 0;
    bit    done = 0;

    function automatic bit is_pulse(int i);
        return (i >= 8 && i < 16) || (i >= 32 && i < 40);
    endfunction

    // line i hit by a write to the bank starting at word base
    function automatic bit bank_hit(int base, int i);
        int a = int'(bus_addr);
        if (a < base || a >= base + 8) return 0;
        if (i / 32 != a - base) return 0;
        return bus_wdata[i % 32];
    endfunction

    task automatic eval();
        int mask, ex, a;
        bit nmi_after, nshow, mshow;
        a = int'(bus_addr);
        m_best = -1;
        for (int i = 0; i < N; i++)
            if (pd[i] != 0 && en[i] != 0 && (m_best < 0 || pr[i] < pr[m_best])) m_best = i;
        m_ret = -1;
        for (int i = 0; i < N; i++)
            if (act[i] != 0 && (m_ret < 0 || pr[i] < pr[m_ret])) m_ret = i;
        m_eretm = (core_eret && nmi_a == 0) ? 1 : 0;
        ex = -1;
        for (int i = 0; i < N; i++)
            if (act[i] != 0 && !(m_eretm != 0 && i == m_ret) && (ex < 0 || pr[i] < pr[ex])) ex = i;
        mask = (255 << (grp + 1)) & 255;
        nmi_after = (nmi_a != 0) && !core_eret;
        nshow = (nmi_pd != 0) && !nmi_after;
        mshow = (m_best >= 0) && !nmi_after && (ex < 0 || (pr[m_best] & mask) < (pr[ex] & mask));
        m_valid = (nshow || mshow) ? 1 : 0;
        m_nmi   = nshow ? 1 : 0;
        m_id    = (!nshow && mshow) ? m_best : 0;
        m_tail  = (core_eret && m_valid != 0) ? 1 : 0;
        m_tnmi  = (core_ack && nshow) ? 1 : 0;
        m_tmask = (core_ack && !nshow && mshow) ? 1 : 0;
        m_rdata = '0;
        if (bus_req && !bus_we && bus_priv) begin
            for (int i = 0; i < N; i++) begin
                if (((a >= 'h40 && a < 'h48) || (a >= 'h60 && a < 'h68)) && (i / 32 == (a & 7)))
                    m_rdata[i % 32] = (en[i] != 0);
                if (((a >= 'h80 && a < 'h88) || (a >= 'hA0 && a < 'hA8)) && (i / 32 == (a & 7)))
                    m_rdata[i % 32] = (pd[i] != 0);
                if (a >= 'h100 && a < 'h13C && (i / 4 == a - 'h100))
                    m_rdata[(i % 4)*8 +: 8] = 8'(pr[i]);
            end
            if (a == 'h140) m_rdata[2:0] = 3'(grp);
        end
    endtask

    always @(posedge clk) begin
        if (!done) begin
            eval();
            if (rst) begin
                for (int i = 0; i < N; i++) begin
                    en[i] = 0; pd[i] = 0; pr[i] = 0; act[i] = 0; lq[i] = 0;
                end
                grp = 0; nmi_q = 0; nmi_pd = 0; nmi_a = 0; err_q = 0;
                started = 1;
            end else begin
                bit wr;
                int a;
                int npd[N];
                wr = bus_req && bus_we && bus_priv;
                a = int'(bus_addr);
                for (int i = 0; i < N; i++) begin
                    bit hw, s, c;
                    hw = is_pulse(i) ? (irq_in[i] && lq[i] == 0) : (irq_in[i] && act[i] == 0);
                    s  = wr && bank_hit('h80, i);
                    c  = (wr && bank_hit('hA0, i)) || (m_tmask != 0 && i == m_best);
                    npd[i] = ((pd[i] != 0 || hw || s) && !c) ? 1 : 0;
                end
                for (int i = 0; i < N; i++) begin
                    pd[i] = npd[i];
                    lq[i] = irq_in[i] ? 1 : 0;
                    if (wr && bank_hit('h40, i)) en[i] = 1;
                    if (wr && bank_hit('h60, i)) en[i] = 0;
                    if (wr && a >= 'h100 && a < 'h13C && i / 4 == a - 'h100)
                        pr[i] = int'(bus_wdata[(i % 4)*8 +: 8]);
                end
                if (m_eretm != 0 && m_ret >= 0) act[m_ret] = 0;
                if (m_tmask != 0) act[m_best] = 1;
                if (wr && a == 'h140) grp = int'(bus_wdata[2:0]);
                nmi_pd = ((nmi_pd != 0 && m_tnmi == 0) || (nmi_in && nmi_q == 0)) ? 1 : 0;
                nmi_a  = ((nmi_a != 0 && !core_eret) || m_tnmi != 0) ? 1 : 0;
                nmi_q  = nmi_in ? 1 : 0;
                err_q  = (bus_req && !bus_priv) ? 1 : 0;
            end
        end
    end

    task automatic chk(string what, longint act_v, longint exp_v);
        n_cmp++;
        if (act_v != exp_v) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", phase, what, act_v, exp_v, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            eval();
            chk("core_irq_valid", longint'(core_irq_valid), longint'(m_valid));
            chk("core_irq_nmi",   longint'(core_irq_nmi),   longint'(m_nmi));
            chk("core_irq_id",    longint'(core_irq_id),    longint'(m_id));
            chk("core_tail",      longint'(core_tail),      longint'(m_tail));
            chk("bus_rdata",      longint'(bus_rdata),      longint'(m_rdata));
            chk("bus_err",        longint'(bus_err),        longint'(err_q));
        end
    end

    task automatic tick(int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(int addr, logic [31:0] data, bit priv = 1);
        bus_req = 1; bus_we = 1; bus_addr = 10'(addr); bus_wdata = data; bus_priv = priv;
        tick();
        bus_req = 0; bus_we = 0; bus_priv = 1; bus_wdata = '0;
    endtask

    task automatic rd(int addr, bit priv = 1);
        bus_req = 1; bus_we = 0; bus_addr = 10'(addr); bus_priv = priv;
        tick();
        bus_req = 0; bus_priv = 1;
    endtask

    task automatic core(bit ack, bit eret);
        core_ack = ack; core_eret = eret;
        tick();
        core_ack = 0; core_eret = 0;
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 20000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        phase = "R1";
        tick(3);
        rst = 0;
        tick(3);

        phase = "R2";
        wr('h40, 32'h0000_00FF);
        rd('h40);
        wr('h40, 32'h0);
        rd('h40);
        wr('h41, 32'h0000_00FF);
        rd('h41);
        rd('h61);

        phase = "R3";
        wr('h60, 32'h0000_000F);
        rd('h40);
        rd('h60);
        wr('h40, 32'h0000_000F);

        phase = "R5";
        wr('h100, 32'h4030_2010);
        wr('h101, 32'h8080_8080);
        wr('h108, 32'h0000_0000);
        rd('h100);
        rd('h101);
        wr('h140, 32'h3);
        rd('h140);

        phase = "R7";
        irq_in[5] = 1; irq_in[4] = 1;
        tick(3);
        irq_in[2] = 1;
        tick(2);
        wr('h100, 32'h40F0_2010);
        tick(2);

        phase = "R9";
        core(1, 0);
        tick(2);
        rd('h80);

        phase = "R8";
        irq_in[1] = 1;
        tick(2);
        core(1, 0);
        wr('h140, 32'h5);
        irq_in[0] = 1;
        tick(2);
        wr('h140, 32'h7);
        tick(2);
        wr('h140, 32'h5);
        tick();

        phase = "R10";
        core(1, 1);
        tick(2);
        irq_in[1:0] = 2'b00;
        core(0, 1);
        tick();
        core(0, 1);
        tick();
        irq_in = '0;
        core(0, 1);
        tick(2);

        phase = "R4";
        wr('hA0, 32'hFFFF_FFFF);
        wr('hA1, 32'hFFFF_FFFF);
        wr('h80, 32'h0000_0008);
        rd('h80);
        rd('hA0);
        wr('hA0, 32'h0000_0008);
        rd('h80);
        irq_in[6] = 1;
        tick(2);
        wr('hA0, 32'h0000_0040);
        rd('h80);
        irq_in[6] = 0;
        tick();
        core(1, 0);
        core(0, 1);
        tick();

        phase = "R6";
        wr('h40, 32'h0000_FF00);
        irq_in[33] = 1;
        tick();
        irq_in[33] = 0;
        tick(2);
        rd('h81);
        core(1, 0);
        irq_in[33] = 1;
        tick();
        irq_in[33] = 0;
        tick();
        core(1, 1);
        tick();
        core(0, 1);
        irq_in[34] = 1;
        tick(5);
        rd('h81);
        core(1, 0);
        tick(3);
        irq_in[34] = 0;
        core(0, 1);
        irq_in[9] = 1;
        tick(2);
        irq_in[9] = 0;
        tick(2);
        wr('hA0, 32'hFFFF_FFFF);
        wr('hA1, 32'hFFFF_FFFF);
        tick();

        phase = "R11";
        irq_in[3] = 1;
        tick(2);
        core(1, 0);
        nmi_in = 1;
        tick(3);
        nmi_in = 0;
        wr('h60, 32'hFFFF_FFFF);
        tick();
        core(1, 0);
        irq_in[2] = 1;
        nmi_in = 1;
        tick();
        nmi_in = 0;
        tick(2);
        core(1, 1);
        tick();
        core(0, 1);
        wr('h40, 32'h0000_0004);
        tick(2);
        core(0, 1);
        tick(2);
        irq_in = '0;

        phase = "R12";
        wr('h40, 32'hFFFF_FFFF, 0);
        rd('h40, 0);
        rd('h40);
        wr('h100, 32'hFFFF_FFFF, 0);
        rd('h100);
        wr('h140, 32'h1, 0);
        rd('h140, 0);
        rd('h140);
        tick(3);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule